// File: doc/BRIEF.md
# Paging Decoder Control and Phase Selector

This block keeps the control settings of a paging-protocol decoder. From them it produces the decode enables that the rest of the decoder uses on each frame and each phase. The host writes a single 14-bit control word over a plain write strobe. The decoder core supplies four things:

- the current frame number and frame-start pulse;
- a block-0 pulse;
- the current data rate;
- address-hit and last-address pulses.

The frame enable is high when the externally computed collapse schedule selects the frame. It is also high when the host has set the force bit for that frame, which is possible for frames 0 to 7. The phase enable is a four-bit mask with bit 0 for phase A through bit 3 for phase D. It covers all phases in all-phase mode. In single-phase mode it holds one phase, picked from the 2-bit phase-select field and remapped by the data rate. While the decoder is running, changes to the phase fields wait for the next block 0. An end-of-addresses flag reports that an own address was found in the frame once the last address word has gone by. A single-cycle pulse restarts an external minute timer.

Control word layout: [7:0] force-frame bits (bit n = frame n), [8] run, [9] single-phase mode, [11:10] phase select, [12] end-of-addresses enable, [13] timer clear. Data-rate codes: 0 = 1600 bit/s, 1 = 3200 bit/s, 2 and 3 = 6400 bit/s. All pins are plain control and status pins. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `pgdec_ctrl`

## Requirements
- R1: After reset every control field is 0. With the collapse match low, the outputs read frame_en=0, phase_en=4'b1111, eoa_flag=0, tmr_clr=0 and dec_on=0.
- R2: frame_en is the OR of collapse_match and the force bit selected by frame_num. A frame number of 8 or more uses only collapse_match; its low bits never select a force bit.
- R3: With single-phase mode clear, phase_en is 4'b1111 at every data rate.
- R4: With single-phase mode set and rate code 0 (1600 bit/s), phase_en is 4'b0001 (phase A) for every phase-select value.
- R5: With single-phase mode set and rate code 1 (3200 bit/s), phase select 00 or 01 gives 4'b0001 (A), and 10 or 11 gives 4'b0100 (C).
- R6: With single-phase mode set and rate code 2 or 3 (6400 bit/s), phase select 00, 01, 10 and 11 give 4'b0001, 4'b0010, 4'b0100 and 4'b1000 (A, B, C, D).
- R7: While the run bit is set, a write of the mode or phase-select fields does not change phase_en. The new values apply in the cycle after the next blk0 pulse. A write in the same cycle as a blk0 pulse waits for the following blk0.
- R8: While the run bit is clear, a write of the mode or phase-select fields shows on phase_en in the cycle after the write.
- R9: With the end-of-addresses enable set, eoa_flag rises in the cycle after a last_addr pulse. This happens only if addr_hit pulsed since the latest frame_start, or in the same cycle as last_addr.
- R10: With the end-of-addresses enable clear, eoa_flag never sets.
- R11: A stat_rd pulse clears eoa_flag in the following cycle. A frame_start pulse discards any address hit seen earlier.
- R12: Each write with the timer-clear bit set gives exactly one tmr_clr pulse in the following cycle. A later write with the bit clear gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 14 | Control word |
| stat_rd | input | 1 | Host status read pulse, clears eoa_flag |
| frame_num | input | 7 | Current frame number |
| frame_start | input | 1 | Start of frame pulse |
| blk0 | input | 1 | Start of block 0 pulse |
| rate | input | 2 | Data-rate code |
| collapse_match | input | 1 | Frame selected by the collapse schedule |
| addr_hit | input | 1 | An enabled address matched |
| last_addr | input | 1 | Last address word of frame decoded |
| frame_en | output | 1 | Decode this frame |
| phase_en | output | 4 | Phase decode mask, bit 0 = A |
| eoa_flag | output | 1 | End-of-addresses status flag |
| tmr_clr | output | 1 | Minute timer clear pulse |
| dec_on | output | 1 | Run bit |

## Verification
The hardest case to reach is a phase write made while running that coincides with a blk0 pulse. The block must then apply the previously pending value and keep the new one for the next block 0. The stimulus first loads one pending value and lets a block 0 apply it. It then writes a second value in the very cycle of another blk0 and checks that the mask keeps the first value until a further blk0. End-of-addresses timing is driven the same way: hits placed before a frame start, hits in the same cycle as the last-address pulse, and a read racing the flag.

// File: rtl/pgdec_pkg.sv
package pgdec_pkg;
  typedef enum logic [1:0] {
    RATE_1600  = 2'd0,
    RATE_3200  = 2'd1,
    RATE_6400  = 2'd2,
    RATE_6400X = 2'd3
  } rate_e;

  // Upper control fields of the write word, above the force-frame bits
  typedef struct packed {
    logic       tclr;
    logic       eoa_en;
    logic [1:0] psel;
    logic       single;
    logic       run;
  } ctl_t;

  localparam int CTL_W   = $bits(ctl_t);
  localparam int PHASE_N = 4;
endpackage

// File: rtl/pgdec_regs.sv
module pgdec_regs
  import pgdec_pkg::*;
#(
  parameter int NUM_FORCE = 8,
  localparam int WORD_W = NUM_FORCE + CTL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic                 blk0,
  output logic [NUM_FORCE-1:0] force_q,
  output logic                 run_q,
  output logic                 single_act,
  output logic [1:0]           psel_act,
  output logic                 eoa_en_q,
  output logic                 tclr_q
);
  ctl_t       wctl;
  logic       single_pend;
  logic [1:0] psel_pend;

  assign wctl = ctl_t'(wr_data[WORD_W-1:NUM_FORCE]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      force_q     <= '0;
      run_q       <= 1'b0;
      eoa_en_q    <= 1'b0;
      tclr_q      <= 1'b0;
      single_pend <= 1'b0;
      psel_pend   <= '0;
      single_act  <= 1'b0;
      psel_act    <= '0;
    end else begin
      tclr_q <= wr_en & wctl.tclr;
      if (wr_en) begin
        force_q     <= wr_data[NUM_FORCE-1:0];
        run_q       <= wctl.run;
        eoa_en_q    <= wctl.eoa_en;
        single_pend <= wctl.single;
        psel_pend   <= wctl.psel;
      end
      if (wr_en && !run_q) begin
        single_act <= wctl.single;
        psel_act   <= wctl.psel;
      end else if (blk0) begin
        single_act <= single_pend;
        psel_act   <= psel_pend;
      end
    end
  end

  AST_PHASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !blk0) |=> ($stable(single_act) && $stable(psel_act))); // R7
  AST_TCLR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tclr_q |-> $past(wr_en)); // R12
endmodule

// File: rtl/pgdec_phase.sv
module pgdec_phase
  import pgdec_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               single,
  input  logic [1:0]         psel,
  input  logic [1:0]         rate,
  output logic [PHASE_N-1:0] phase_en
);
  logic [1:0] idx;

  always_comb begin
    unique case (rate_e'(rate))
      RATE_1600: idx = 2'd0;
      RATE_3200: idx = {psel[1], 1'b0};
      default:   idx = psel;
    endcase
  end

  always_comb begin
    if (!single) phase_en = '1;
    else         phase_en = PHASE_N'(1) << idx;
  end

  AST_SINGLE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    single |-> ($countones(phase_en) == 1)); // R4
  AST_SLOW_RATE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (single && rate == 2'd0) |-> phase_en[0]); // R4
  AST_MID_RATE_NO_BD: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == 2'd1) |-> (phase_en[0] || phase_en[2])); // R5
endmodule

// File: rtl/pgdec_frame.sv
module pgdec_frame #(
  parameter int NUM_FORCE = 8,
  parameter int FRAME_W   = 7,
  localparam int IDX_W = $clog2(NUM_FORCE)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [FRAME_W-1:0]   frame_num,
  input  logic                 collapse_match,
  input  logic [NUM_FORCE-1:0] force_bits,
  output logic                 frame_en
);
  logic in_range;
  logic forced;

  assign in_range = frame_num < FRAME_W'(NUM_FORCE);
  assign forced   = in_range && force_bits[frame_num[IDX_W-1:0]];
  assign frame_en = collapse_match | forced;

  AST_COLLAPSE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    collapse_match |-> frame_en); // R2
  AST_HIGH_FRAME_ONLY_COLLAPSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_range && !collapse_match) |-> !frame_en); // R2
endmodule

// File: rtl/pgdec_eoa.sv
module pgdec_eoa (
  input  logic clk,
  input  logic rst_n,
  input  logic eoa_en,
  input  logic frame_start,
  input  logic addr_hit,
  input  logic last_addr,
  input  logic stat_rd,
  output logic eoa_flag
);
  logic hit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q    <= 1'b0;
      eoa_flag <= 1'b0;
    end else begin
      if (frame_start)   hit_q <= addr_hit;
      else if (addr_hit) hit_q <= 1'b1;
      if (last_addr && eoa_en && (hit_q || addr_hit)) eoa_flag <= 1'b1;
      else if (stat_rd)                               eoa_flag <= 1'b0;
    end
  end

  AST_FLAG_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoa_flag) |-> $past(eoa_en && last_addr)); // R10
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !last_addr) |=> !eoa_flag); // R11
endmodule

// File: rtl/pgdec_ctrl.sv
module pgdec_ctrl
  import pgdec_pkg::*;
#(
  parameter int NUM_FORCE = 8,
  parameter int FRAME_W   = 7,
  localparam int WORD_W = NUM_FORCE + CTL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic               stat_rd,
  input  logic [FRAME_W-1:0] frame_num,
  input  logic               frame_start,
  input  logic               blk0,
  input  logic [1:0]         rate,
  input  logic               collapse_match,
  input  logic               addr_hit,
  input  logic               last_addr,
  output logic               frame_en,
  output logic [PHASE_N-1:0] phase_en,
  output logic               eoa_flag,
  output logic               tmr_clr,
  output logic               dec_on
);
  logic [NUM_FORCE-1:0] force_q;
  logic                 single_act;
  logic [1:0]           psel_act;
  logic                 eoa_en_q;

  pgdec_regs #(.NUM_FORCE(NUM_FORCE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .blk0(blk0),
    .force_q(force_q), .run_q(dec_on), .single_act(single_act),
    .psel_act(psel_act), .eoa_en_q(eoa_en_q), .tclr_q(tmr_clr)
  );

  pgdec_frame #(.NUM_FORCE(NUM_FORCE), .FRAME_W(FRAME_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .frame_num(frame_num),
    .collapse_match(collapse_match), .force_bits(force_q), .frame_en(frame_en)
  );

  pgdec_phase u_phase (
    .clk(clk), .rst_n(rst_n), .single(single_act), .psel(psel_act),
    .rate(rate), .phase_en(phase_en)
  );

  pgdec_eoa u_eoa (
    .clk(clk), .rst_n(rst_n), .eoa_en(eoa_en_q), .frame_start(frame_start),
    .addr_hit(addr_hit), .last_addr(last_addr), .stat_rd(stat_rd),
    .eoa_flag(eoa_flag)
  );

  AST_ALL_PHASES: assert property (@(posedge clk) disable iff (!rst_n)
    !single_act |-> (phase_en == '1)); // R3
endmodule

// File: tb/sim_pgdec_ctrl.sv
`timescale 1ns/1ps
module sim_pgdec_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [13:0] wr_data = '0;
  logic        stat_rd = 1'b0;
  logic [6:0]  frame_num = '0;
  logic        frame_start = 1'b0;
  logic        blk0 = 1'b0;
  logic [1:0]  rate = 2'd0;
  logic        collapse_match = 1'b0;
  logic        addr_hit = 1'b0;
  logic        last_addr = 1'b0;
  logic        frame_en, eoa_flag, tmr_clr, dec_on;
  logic [3:0]  phase_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  string       rq[$];
  logic [7:0]  eq[$];
  logic [7:0]  mq[$];

  localparam logic [7:0] M_FE = 8'h80, M_PH = 8'h78, M_EA = 8'h04,
                         M_TC = 8'h02, M_ON = 8'h01;

  always #2.5 clk = ~clk;

  pgdec_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .stat_rd(stat_rd), .frame_num(frame_num), .frame_start(frame_start),
    .blk0(blk0), .rate(rate), .collapse_match(collapse_match),
    .addr_hit(addr_hit), .last_addr(last_addr), .frame_en(frame_en),
    .phase_en(phase_en), .eoa_flag(eoa_flag), .tmr_clr(tmr_clr),
    .dec_on(dec_on)
  );

  wire [7:0] obs = {frame_en, phase_en, eoa_flag, tmr_clr, dec_on};

  function automatic logic [13:0] cw(logic [7:0] f, logic on, logic sp,
                                     logic [1:0] ps, logic ea, logic tc);
    return {tc, ea, ps, sp, on, f};
  endfunction

  function automatic logic [7:0] ph(logic [3:0] p);
    return {1'b0, p, 3'b000};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
    wr_en = 1'b0; blk0 = 1'b0; frame_start = 1'b0;
    addr_hit = 1'b0; last_addr = 1'b0; stat_rd = 1'b0;
  endtask

  task automatic expect_out(string r, logic [7:0] m, logic [7:0] e);
    rq.push_back(r); mq.push_back(m); eq.push_back(e);
  endtask

  task automatic wr(logic [13:0] d);
    tick();
    wr_en = 1'b1; wr_data = d;
  endtask

  // Monitor: pops expectations pushed in this cycle and compares
  always @(negedge clk) begin
    while (eq.size() > 0) begin
      string r;
      logic [7:0] e, m;
      r = rq.pop_front(); e = eq.pop_front(); m = mq.pop_front();
      checks++;
      if (((obs ^ e) & m) != 8'h00) begin
        errors++;
        $display("FAIL %s got %h expected %h (mask %h)", r, obs & m, e & m, m);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    tick(); rst_n = 1'b1;
    expect_out("R1", 8'hFF, 8'h78);

    // R2 frame enable
    tick(); collapse_match = 1'b1; frame_num = 7'd20; expect_out("R2", M_FE, 8'h80);
    tick(); collapse_match = 1'b0; frame_num = 7'd3;  expect_out("R2", M_FE, 8'h00);
    wr(cw(8'h04, 0, 0, 2'd0, 0, 0));
    tick(); frame_num = 7'd2;  expect_out("R2", M_FE, 8'h80);
    tick(); frame_num = 7'd3;  expect_out("R2", M_FE, 8'h00);
    tick(); frame_num = 7'd10; expect_out("R2", M_FE, 8'h00);
    tick(); frame_num = 7'd7; collapse_match = 1'b1; expect_out("R2", M_FE, 8'h80);
    tick(); collapse_match = 1'b0;

    // R8 immediate while off, rate mapping R4 R5 R6
    wr(cw(8'h00, 0, 1, 2'd3, 0, 0)); rate = 2'd2;
    tick(); expect_out("R8", M_PH, ph(4'b1000));
    tick(); rate = 2'd1; expect_out("R5", M_PH, ph(4'b0100));
    tick(); rate = 2'd0; expect_out("R4", M_PH, ph(4'b0001));
    tick(); rate = 2'd3; expect_out("R6", M_PH, ph(4'b1000));
    wr(cw(8'h00, 0, 1, 2'd1, 0, 0)); rate = 2'd2;
    tick(); expect_out("R6", M_PH, ph(4'b0010));
    tick(); rate = 2'd1; expect_out("R5", M_PH, ph(4'b0001));
    tick(); rate = 2'd0; expect_out("R4", M_PH, ph(4'b0001));
    wr(cw(8'h00, 0, 1, 2'd2, 0, 0)); rate = 2'd2;
    tick(); expect_out("R6", M_PH, ph(4'b0100));
    tick(); rate = 2'd1; expect_out("R5", M_PH, ph(4'b0100));
    wr(cw(8'h00, 0, 1, 2'd0, 0, 0)); rate = 2'd2;
    tick(); expect_out("R6", M_PH, ph(4'b0001));
    wr(cw(8'h00, 0, 0, 2'd3, 0, 0));
    tick(); expect_out("R3", M_PH, ph(4'b1111));
    tick(); rate = 2'd0; expect_out("R3", M_PH, ph(4'b1111));
    tick(); rate = 2'd2;

    // R7 deferred while on
    wr(cw(8'h00, 1, 0, 2'd0, 0, 0));
    tick(); expect_out("R7", M_ON, 8'h01);
    wr(cw(8'h00, 1, 1, 2'd1, 0, 0));
    tick(); expect_out("R7", M_PH, ph(4'b1111));
    tick(); expect_out("R7", M_PH, ph(4'b1111));
    tick(); blk0 = 1'b1; expect_out("R7", M_PH, ph(4'b1111));
    tick(); expect_out("R7", M_PH, ph(4'b0010));
    wr(cw(8'h00, 1, 1, 2'd3, 0, 0)); blk0 = 1'b1;
    tick(); expect_out("R7", M_PH, ph(4'b0010));
    tick(); expect_out("R7", M_PH, ph(4'b0010));
    tick(); blk0 = 1'b1;
    tick(); expect_out("R7", M_PH, ph(4'b1000));

    // R9 R11 end-of-addresses
    wr(cw(8'h00, 1, 1, 2'd3, 1, 0));
    tick(); frame_start = 1'b1;
    tick(); addr_hit = 1'b1;
    tick(); last_addr = 1'b1; expect_out("R9", M_EA, 8'h00);
    tick(); expect_out("R9", M_EA, 8'h04);
    tick(); stat_rd = 1'b1; expect_out("R11", M_EA, 8'h04);
    tick(); expect_out("R11", M_EA, 8'h00);
    tick(); frame_start = 1'b1;
    tick(); last_addr = 1'b1;
    tick(); expect_out("R11", M_EA, 8'h00);
    tick(); addr_hit = 1'b1;
    tick(); frame_start = 1'b1;
    tick(); last_addr = 1'b1;
    tick(); expect_out("R11", M_EA, 8'h00);
    tick(); addr_hit = 1'b1; last_addr = 1'b1;
    tick(); expect_out("R9", M_EA, 8'h04);
    tick(); stat_rd = 1'b1;
    tick(); expect_out("R11", M_EA, 8'h00);

    // R10 enable clear
    wr(cw(8'h00, 1, 1, 2'd3, 0, 0));
    tick(); frame_start = 1'b1;
    tick(); addr_hit = 1'b1;
    tick(); last_addr = 1'b1;
    tick(); expect_out("R10", M_EA, 8'h00);
    tick(); addr_hit = 1'b1; last_addr = 1'b1;
    tick(); expect_out("R10", M_EA, 8'h00);

    // R12 timer clear pulse
    wr(cw(8'h00, 1, 1, 2'd3, 0, 1));
    tick(); expect_out("R12", M_TC, 8'h02);
    tick(); expect_out("R12", M_TC, 8'h00);
    wr(cw(8'h00, 1, 1, 2'd3, 0, 0));
    tick(); expect_out("R12", M_TC, 8'h00);
    tick(); expect_out("R12", M_TC, 8'h00);

    tick(); tick();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule